// File: doc/BRIEF.md
# Interrupt Priority Stack with End-of-Interrupt

This block keeps the priority at which the processor is currently servicing interrupts. It holds earlier priorities in a small last-in-first-out stack. When an acknowledge strobe arrives with a new request's priority and vector, the block saves the running priority on the stack and adopts the new one in the same cycle. It also keeps the vector, which becomes part of an acknowledge word.

Software ends a service routine by writing the end-of-interrupt register. Any write there, whatever its data or byte lanes, restores the most recently saved priority. The acknowledge word joins a table base taken from a configuration register with the captured vector. When a configuration bit asks for larger vector table entries, the vector sits one place further left. Arbitration among interrupt sources happens elsewhere.

Top module: `irq_prio_stack`

## Requirements
- R1: After reset the current priority is 0, the stack is empty (level 0), both error flags are 0, and the configuration and acknowledge words read 0.
- R2: A one-cycle `ack_valid` strobe pushes the current priority and loads `ack_prio` as the current priority at the same clock edge, raising the level by one. Register offset 0x0 reads the current priority in bits [3:0] and zeros above.
- R3: Any bus write to offset 0x8 (end-of-interrupt) pops the last saved priority into the current priority and lowers the level by one. Write data and byte enables play no part, so even a write with no byte lane enabled pops. Priorities come back in reverse order of pushing.
- R4: A read of offset 0x8 returns zero and leaves the stack and current priority unchanged.
- R5: An acknowledge with 8 entries on the stack leaves the stack unchanged and still loads the new priority and vector. It sets `err_overflow`, which stays set until reset.
- R6: An end-of-interrupt write with an empty stack leaves the current priority unchanged. It sets `err_underflow`, which stays set until reset.
- R7: When an acknowledge and an end-of-interrupt write fall in the same cycle, the acknowledge is carried out and the end-of-interrupt is dropped.
- R8: With configuration bit 0 clear, the acknowledge word (offset 0x4) holds configuration bits [31:11] in [31:11], the vector in [10:2], and zeros in [1:0].
- R9: With configuration bit 0 set, the acknowledge word holds configuration bits [31:12] in [31:12], the vector in [11:3], and zeros in [2:0].
- R10: The vector field takes `ack_vec` on every acknowledge strobe, including one that overflows the stack.
- R11: The configuration register (offset 0xC) is written per byte lane: `bus_be[k]` enables bits [8k+7:8k]. It reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the register |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_prio | input | 4 | Priority of the acknowledged request |
| ack_vec | input | 9 | Vector of the acknowledged request |
| cur_prio | output | 4 | Current processor priority |
| stack_level | output | 4 | Number of saved priorities |
| err_overflow | output | 1 | Sticky: acknowledge with full stack |
| err_underflow | output | 1 | Sticky: end-of-interrupt with empty stack |

## Verification
Every cycle, the assertions check several rules. The level stays within the depth and moves by exactly one on each carried-out push or pop. An acknowledge is followed by its priority, and a pop by the old stack top. Both error flags stay set once raised, and an empty-stack pop leaves the priority alone. The low bits of the acknowledge word are zero in both layouts, and a read of the end-of-interrupt register returns zero. Only the bench's scenarios can show the rest: priorities return in reverse order over long sequences, the exact bit placement of base and vector, byte-lane configuration writes, pops driven by odd data and empty byte enables, and the outcome of an acknowledge that collides with an end-of-interrupt.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 9;

  typedef enum logic [1:0] {
    REG_CPR = 2'd0,
    REG_ACK = 2'd1,
    REG_EOI = 2'd2,
    REG_CFG = 2'd3
  } reg_sel_e;

  // Join table base and vector; a wide entry shifts the vector up one bit.
  function automatic logic [DATA_W-1:0] pack_ack_word(
      input logic [DATA_W-1:0] cfg, input logic [VEC_W-1:0] vec);
    logic [DATA_W-1:0] w;
    w = '0;
    if (cfg[0]) begin
      w[31:12] = cfg[31:12];
      w[11:3]  = vec;
    end else begin
      w[31:11] = cfg[31:11];
      w[10:2]  = vec;
    end
    return w;
  endfunction

  // Byte-lane merge for configuration writes.
  function automatic logic [DATA_W-1:0] merge_bytes(
      input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
      input logic [DATA_W/8-1:0] be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int k = 0; k < DATA_W/8; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [W-1:0]     push_data,
  output logic [W-1:0]     top_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_done,
  output logic             pop_done
);
  logic [W-1:0]     mem [DEPTH];
  logic [LVL_W-1:0] top_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_done = push_req & ~full;
  assign pop_done  = pop_req & ~empty & ~push_req;
  assign top_idx   = level - 1'b1;
  assign wr_idx    = level[IDX_W-1:0];
  assign rd_idx    = top_idx[IDX_W-1:0];
  assign top_data  = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_done) begin
      mem[wr_idx] <= push_data;
      level       <= level + 1'b1;
    end else if (pop_done) begin
      level <= level - 1'b1;
    end
  end

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> level == $past(level) + 1'b1);
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |=> level == $past(level) - 1'b1);
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req & full) |=> $stable(level));
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_prio_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [DATA_W-1:0] ack_word,
  input  logic [DATA_W-1:0] cfg_word,
  output logic              eoi_wr_evt,
  output logic              cfg_wr_evt,
  output logic              eoi_rd_evt,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;
  logic     unused_lsb;

  assign sel        = reg_sel_e'(bus_addr[3:2]);
  assign unused_lsb = ^bus_addr[1:0];
  assign eoi_wr_evt = bus_sel & bus_wr & (sel == REG_EOI);
  assign cfg_wr_evt = bus_sel & bus_wr & (sel == REG_CFG);
  assign eoi_rd_evt = bus_sel & ~bus_wr & (sel == REG_EOI);

  always_comb begin
    rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (sel)
        REG_CPR: rdata = DATA_W'(cur_prio);
        REG_ACK: rdata = ack_word;
        REG_EOI: rdata = '0;
        REG_CFG: rdata = cfg_word;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
  import irq_prio_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ack_valid,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic [8:0]        ack_vec,
  output logic [PRIO_W-1:0] cur_prio,
  output logic [LVL_W-1:0]  stack_level,
  output logic              err_overflow,
  output logic              err_underflow
);
  logic [VEC_W-1:0]  vec_q;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] ack_word;
  logic [PRIO_W-1:0] top_data;
  logic eoi_wr_evt, cfg_wr_evt, eoi_rd_evt;
  logic eoi_evt, full, empty, push_done, pop_done;

  // An acknowledge in the same cycle takes precedence over end-of-interrupt.
  assign eoi_evt  = eoi_wr_evt & ~ack_valid;
  assign ack_word = pack_ack_word(cfg_q, vec_q);

  prio_lifo #(.DEPTH(DEPTH), .W(PRIO_W)) u_lifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(ack_valid), .pop_req(eoi_evt), .push_data(cur_prio),
    .top_data(top_data), .level(stack_level), .full(full), .empty(empty),
    .push_done(push_done), .pop_done(pop_done)
  );

  irq_reg_decode #(.PRIO_W(PRIO_W)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cur_prio(cur_prio), .ack_word(ack_word), .cfg_word(cfg_q),
    .eoi_wr_evt(eoi_wr_evt), .cfg_wr_evt(cfg_wr_evt), .eoi_rd_evt(eoi_rd_evt),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio      <= '0;
      vec_q         <= '0;
      cfg_q         <= '0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      if (ack_valid) begin
        cur_prio <= ack_prio;
        vec_q    <= ack_vec;
      end else if (pop_done) begin
        cur_prio <= top_data;
      end
      if (ack_valid && full) err_overflow <= 1'b1;
      if (eoi_evt && empty)  err_underflow <= 1'b1;
      if (cfg_wr_evt) cfg_q <= merge_bytes(cfg_q, bus_wdata, bus_be);
    end
  end

  assert_ack_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> cur_prio == $past(ack_prio));
  assert_pop_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |=> cur_prio == $past(top_data));
  assert_eoi_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_rd_evt |-> bus_rdata == '0);
  assert_eoi_read_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_rd_evt & ~ack_valid) |=> $stable(stack_level) && $stable(cur_prio));
  assert_no_overflow_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
  assert_no_underflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
  assert_empty_pop_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt & empty) |=> $stable(cur_prio) && err_underflow);
  assert_collide_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid & eoi_wr_evt & ~full) |=> stack_level == $past(stack_level) + 1'b1);
  assert_vec_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> vec_q == $past(ack_vec));

  always_comb begin
    if (rst_n) begin
      if (cfg_q[0]) assert_wide_low_zero_R9: assert (ack_word[2:0] == 3'b000);
      else          assert_narrow_low_zero_R8: assert (ack_word[1:0] == 2'b00);
    end
  end
endmodule

// File: tb/tb_irq_prio_stack.sv
module tb_irq_prio_stack;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // Each entry: {is_eoi, prio, exp_cur, exp_level}
  localparam logic [12:0] VECS [NVEC] = '{
    {1'b0, 4'd5,  4'd5,  4'd1},
    {1'b0, 4'd9,  4'd9,  4'd2},
    {1'b1, 4'd0,  4'd5,  4'd1},
    {1'b0, 4'd3,  4'd3,  4'd2},
    {1'b0, 4'd15, 4'd15, 4'd3},
    {1'b1, 4'd0,  4'd3,  4'd2},
    {1'b1, 4'd0,  4'd5,  4'd1},
    {1'b1, 4'd0,  4'd0,  4'd0}
  };

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ack_valid = 0;
  logic [3:0] ack_prio = '0;
  logic [8:0] ack_vec = '0;
  logic [3:0] cur_prio, stack_level;
  logic err_overflow, err_underflow;
  int n_tests = 0, n_fail = 0, cycles = 0;
  logic done = 0;

  irq_prio_stack dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_ack(input logic [3:0] p, input logic [8:0] v);
    @(negedge clk); ack_valid = 1; ack_prio = p; ack_vec = v;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  function automatic logic [31:0] exp_ack(input logic [31:0] cfg, input logic [8:0] v);
    if (cfg[0]) return (cfg & 32'hFFFF_F000) | ({23'd0, v} << 3);
    return (cfg & 32'hFFFF_F800) | ({23'd0, v} << 2);
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cur", cur_prio, 0);
    chk("R1 level", stack_level, 0);
    chk("R1 flags", {err_overflow, err_underflow}, 0);
    bus_read(4'h4, rd); chk("R1 ack word", rd, 0);
    bus_read(4'hC, rd); chk("R1 cfg", rd, 0);

    // R2/R3 table walk; EOI data and byte enables vary to show they are ignored
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][12])
        bus_write(4'h8, 32'hDEAD_0000 ^ i, 4'(i));
      else
        do_ack(VECS[i][11:8], 9'(i * 37));
      chk(VECS[i][12] ? "R3 pop cur" : "R2 push cur", cur_prio, {28'd0, VECS[i][7:4]});
      chk(VECS[i][12] ? "R3 pop level" : "R2 push level", stack_level, {28'd0, VECS[i][3:0]});
    end
    bus_write(4'h0, 32'hFFFF_FFFF, 4'hF);
    do_ack(4'd11, 9'd1);
    bus_read(4'h0, rd); chk("R2 cpr read", rd, 32'd11);
    bus_write(4'h8, 32'h0, 4'h0);
    chk("R3 pop with no lanes", cur_prio, 0);

    // R6 underflow
    bus_write(4'h8, 32'h1234_5678, 4'hF);
    chk("R6 cur unchanged", cur_prio, 0);
    chk("R6 level", stack_level, 0);
    chk("R6 flag", err_underflow, 1);

    // R7 collision: acknowledge wins
    @(negedge clk);
    ack_valid = 1; ack_prio = 4'd4; ack_vec = 9'h0AA;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h8; bus_be = 4'hF;
    @(negedge clk);
    ack_valid = 0; bus_sel = 0; bus_wr = 0;
    chk("R7 cur", cur_prio, 4);
    chk("R7 level", stack_level, 1);

    // R4 EOI read
    bus_read(4'h8, rd);
    chk("R4 read zero", rd, 0);
    chk("R4 level kept", stack_level, 1);
    chk("R4 cur kept", cur_prio, 4);
    bus_write(4'h8, 32'h0, 4'hF);
    chk("R3 back to 0", cur_prio, 0);
    chk("R6 still sticky", err_underflow, 1);

    // R5 overflow, R10 vector on overflow
    for (int p = 1; p <= 8; p++) do_ack(4'(p), 9'(p));
    chk("R5 full level", stack_level, 8);
    chk("R5 flag clear before", err_overflow, 0);
    do_ack(4'd9, 9'h1C3);
    chk("R5 cur loads", cur_prio, 9);
    chk("R5 level held", stack_level, 8);
    chk("R5 flag", err_overflow, 1);
    bus_read(4'h4, rd); chk("R10 vector on overflow", rd, exp_ack(32'h0, 9'h1C3));
    bus_write(4'h8, 32'h0, 4'hF);
    chk("R5 top kept", cur_prio, 7);
    chk("R5 sticky", err_overflow, 1);

    // R11 byte-lane config, R8/R9 layouts
    bus_write(4'hC, 32'hABCD_EFFE, 4'hF);
    bus_read(4'hC, rd); chk("R11 full write", rd, 32'hABCD_EFFE);
    bus_read(4'h4, rd); chk("R8 narrow", rd, exp_ack(32'hABCD_EFFE, 9'h1C3));
    do_ack(4'd2, 9'h155);
    bus_read(4'h4, rd); chk("R10 narrow new vec", rd, exp_ack(32'hABCD_EFFE, 9'h155));
    bus_write(4'hC, 32'h0000_0001, 4'h1);
    bus_read(4'hC, rd); chk("R11 lane0 only", rd, 32'hABCD_EF01);
    bus_read(4'h4, rd); chk("R9 wide", rd, exp_ack(32'hABCD_EF01, 9'h155));
    chk("R9 low bits", rd[2:0], 0);
    bus_write(4'hC, 32'h1200_0000, 4'h8);
    bus_read(4'hC, rd); chk("R11 lane3 only", rd, 32'h12CD_EF01);
    bus_read(4'h4, rd); chk("R9 wide base", rd, exp_ack(32'h12CD_EF01, 9'h155));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule